// File: doc/BRIEF.md
# Synthesizer Self-Tune and Settle Sequencer

This block sequences one frequency-synthesizer section through its start-up. It divides the reference clock into phase-detector update ticks, one every R reference cycles, or one every 2R cycles when the reference halving option is selected. Each time the section is enabled, and each time a new frequency is programmed while it is enabled, the sequencer restarts. It first spends a fixed number of update periods in a self-tuning window, then counts a further number of periods of loop control before it reports the output as settled.

An active-low lock-detect flag stays high while the section is off, idle or tuning. After tuning it follows a drift input that models the loop nearing the edge of its correction range, so a controller can trigger a retune. The legal range of R depends on the phase-detector gain code. An illegal R raises a sticky error and parks the sequencer until a legal R is written again.

Top module: `pll_tune_seq`

## Requirements
- R1: After reset, upd_tick, tuning, settled and r_error are 0 and lock_det_n is 1.
- R2: With halve = 0, update ticks are spaced R reference cycles apart. The first tick appears R cycles after the restart edge.
- R3: With halve = 1, update ticks are spaced 2R reference cycles apart. The first tick appears 2R cycles after the restart edge.
- R4: A rising edge on enable, or a new_freq pulse while enable is high and R is legal, starts a restart. tuning is 1 from the next cycle.
- R5: The tuning window spans 13 update ticks. tuning falls in the same cycle that the 13th tick pulse appears.
- R6: lock_det_n is 1 while the section is off, idle on an error, or tuning. It is 0 after tuning while near_limit is 0.
- R7: After tuning, near_limit = 1 drives lock_det_n to 1 one cycle later, and lock_det_n returns to 0 one cycle after near_limit clears.
- R8: settled rises together with the 38th update tick after tuning ends, and then stays high.
- R9: enable = 0 clears settled and tuning from the next cycle, forces lock_det_n to 1 and stops all ticks.
- R10: R is legal when it is at least the gain minimum and at most 8189. The gain minimums are 7, 8, 10 and 14 for gain codes 0, 1, 2 and 3. An illegal R while enabled sets r_error in the next cycle and idles the sequencer, with no ticks and lock_det_n at 1.
- R11: r_error stays set after R becomes legal, and through power-down. It clears only at a restart with a legal R, and tuning starts at that same restart.
- R12: If a restart coincides with the update tick that would complete settling, the restart wins: settled stays 0, tuning is 1 and no tick pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Section powered when 1 |
| new_freq | input | 1 | One-cycle pulse: new frequency programmed |
| r_val | input | 13 | Reference divider value R |
| gain | input | 2 | Phase-detector gain code |
| halve | input | 1 | Divide the reference by 2 before R |
| near_limit | input | 1 | Loop near the end of its correction range |
| upd_tick | output | 1 | One-cycle phase-detector update pulse |
| tuning | output | 1 | Self-tuning window active |
| lock_det_n | output | 1 | Active-low lock detect |
| settled | output | 1 | Output frequency settled |
| r_error | output | 1 | Sticky illegal-R flag |

## Verification
The sharpest overlap is a restart landing on the same edge as the update tick that would finish settling. The bench counts ticks through the locking phase and, after the 37th one, waits one period less a cycle before it pulses new_freq. That makes the request meet the 38th divider wrap exactly. The outcome is judged at the ports: settled must still be 0, tuning must be 1 and the tick pulse must be absent. A second overlap, an illegal R arriving together with a write, is judged by r_error rising while tuning stays low.

// File: rtl/pll_tune_seq.sv
module pll_tune_seq #(
  parameter int RW           = 13,
  parameter int R_MAX        = 8189,
  parameter int TUNE_TICKS   = 13,
  parameter int SETTLE_TICKS = 38,
  parameter int MIN_R_G0     = 7,
  parameter int MIN_R_G1     = 8,
  parameter int MIN_R_G2     = 10,
  parameter int MIN_R_G3     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          new_freq,
  input  logic [RW-1:0] r_val,
  input  logic [1:0]    gain,
  input  logic          halve,
  input  logic          near_limit,
  output logic          upd_tick,
  output logic          tuning,
  output logic          lock_det_n,
  output logic          settled,
  output logic          r_error
);
  localparam int MAXT = (TUNE_TICKS > SETTLE_TICKS) ? TUNE_TICKS : SETTLE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_TUNE, S_LOCK, S_DONE} st_t;

  st_t           state;
  logic [RW-1:0] div_cnt;
  logic [CW-1:0] tcnt;
  logic          pre, en_q, near_q;
  logic [RW-1:0] r_min;

  always_comb begin
    case (gain)
      2'd0:    r_min = RW'(MIN_R_G0);
      2'd1:    r_min = RW'(MIN_R_G1);
      2'd2:    r_min = RW'(MIN_R_G2);
      default: r_min = RW'(MIN_R_G3);
    endcase
  end

  wire r_ok    = (r_val >= r_min) && (r_val <= RW'(R_MAX));
  wire restart = enable & (new_freq | ~en_q);
  wire active  = (state == S_TUNE) || (state == S_LOCK) || (state == S_DONE);
  wire advance = active & (~halve | pre);
  wire wrap    = advance & (div_cnt >= r_val - 1'b1);
  wire locking = (state == S_LOCK) || (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      div_cnt  <= '0;
      tcnt     <= '0;
      pre      <= 1'b0;
      en_q     <= 1'b0;
      near_q   <= 1'b0;
      upd_tick <= 1'b0;
      r_error  <= 1'b0;
    end else begin
      en_q     <= enable;
      near_q   <= near_limit;
      upd_tick <= 1'b0;
      if (!enable) begin
        state   <= S_OFF;
        div_cnt <= '0;
        tcnt    <= '0;
        pre     <= 1'b0;
      end else if (!r_ok) begin
        state   <= S_IDLE;
        r_error <= 1'b1;
        div_cnt <= '0;
        tcnt    <= '0;
        pre     <= 1'b0;
      end else if (restart) begin
        state   <= S_TUNE;
        r_error <= 1'b0;
        div_cnt <= '0;
        tcnt    <= '0;
        pre     <= 1'b0;
      end else if (active) begin
        if (halve) pre <= ~pre;
        if (wrap) begin
          div_cnt  <= '0;
          upd_tick <= 1'b1;
          case (state)
            S_TUNE:
              if (tcnt == CW'(TUNE_TICKS - 1)) begin
                state <= S_LOCK;
                tcnt  <= '0;
              end else tcnt <= tcnt + 1'b1;
            S_LOCK:
              if (tcnt == CW'(SETTLE_TICKS - 1)) begin
                state <= S_DONE;
                tcnt  <= '0;
              end else tcnt <= tcnt + 1'b1;
            default: ;
          endcase
        end else if (advance) begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign tuning     = (state == S_TUNE);
  assign settled    = (state == S_DONE);
  assign lock_det_n = ~locking | near_q;
endmodule

// File: rtl/pll_tune_seq_chk.sv
module pll_tune_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic new_freq,
  input logic near_limit,
  input logic upd_tick,
  input logic tuning,
  input logic lock_det_n,
  input logic settled,
  input logic r_error
);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!upd_tick && !tuning && !settled && lock_det_n));

  p_tune_hides_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tuning |-> lock_det_n);

  p_restart_tunes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && new_freq) |=> (tuning || r_error));

  p_settled_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (!tuning && !r_error));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_error |-> (!upd_tick && !tuning && lock_det_n));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (r_error && !new_freq && $stable(enable)) |=> r_error);

  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> !upd_tick);

  p_near_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(near_limit)) |-> lock_det_n);
endmodule

bind pll_tune_seq pll_tune_seq_chk chk_i (.*);

// File: tb/pll_tune_seq_tb_top.sv
module pll_tune_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, new_freq = 1'b0, halve = 1'b0, near_limit = 1'b0;
  logic [12:0] r_val = 13'd7;
  logic [1:0] gain = 2'd0;
  logic upd_tick, tuning, lock_det_n, settled, r_error;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  pll_tune_seq dut_i (.clk(clk), .rst_n(rst_n), .enable(enable), .new_freq(new_freq),
    .r_val(r_val), .gain(gain), .halve(halve), .near_limit(near_limit),
    .upd_tick(upd_tick), .tuning(tuning), .lock_det_n(lock_det_n),
    .settled(settled), .r_error(r_error));

  localparam int NV = 10;
  localparam int VR [NV] = '{7, 6, 8, 7, 10, 9, 14, 13, 8189, 8190};
  localparam int VG [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 3, 0};
  localparam int VH [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0};
  localparam int VK [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 2, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_full(input int r, input int g, input int h);
    int p, k, n;
    bit done;
    p = h ? 2 * r : r;
    r_val = 13'(r); gain = 2'(g); halve = h[0]; new_freq = 1'b1;
    step();
    new_freq = 1'b0;
    chk(tuning == 1'b1 && r_error == 1'b0, "R4", int'(tuning), 1);
    k = 0; n = 0; done = 0;
    while (!done && k < 60 * p) begin
      step();
      k++;
      if (upd_tick) begin
        n++;
        if (n == 1) chk(k == p, h ? "R3" : "R2", k, p);
        if (n == 12) chk(tuning && lock_det_n, "R6", int'(lock_det_n), 1);
        if (n == 13) chk(!tuning && !lock_det_n, "R5", int'(tuning), 0);
        if (n == 50) chk(!settled, "R8", int'(settled), 0);
        if (n == 51) begin
          chk(settled == 1'b1, "R8", int'(settled), 1);
          done = 1;
        end
      end
    end
    chk(done, "R8", n, 51);
  endtask

  initial begin
    int saw;
    #5;
    chk(!upd_tick && !tuning && !settled && lock_det_n && !r_error, "R1", int'(lock_det_n), 1);
    step();
    rst_n = 1'b1;
    step();
    chk(!tuning && !settled && lock_det_n && !r_error, "R1", int'(tuning), 0);
    enable = 1'b1;
    step();
    chk(tuning == 1'b1, "R4", int'(tuning), 1);

    for (int i = 0; i < NV; i++) begin
      if (VK[i] == 1) run_full(VR[i], VG[i], VH[i]);
      else begin
        r_val = 13'(VR[i]); gain = 2'(VG[i]); halve = VH[i][0]; new_freq = 1'b1;
        step();
        new_freq = 1'b0;
        if (VK[i] == 2) chk(tuning && !r_error, "R10", int'(r_error), 0);
        else begin
          chk(r_error && !tuning && lock_det_n, "R10", int'(r_error), 1);
          saw = 0;
          for (int j = 0; j < 40; j++) begin step(); if (upd_tick) saw++; end
          chk(saw == 0 && lock_det_n, "R10", saw, 0);
        end
      end
    end

    run_full(7, 0, 0);
    near_limit = 1'b1;
    step();
    chk(lock_det_n == 1'b1 && settled, "R7", int'(lock_det_n), 1);
    near_limit = 1'b0;
    step();
    chk(lock_det_n == 1'b0, "R7", int'(lock_det_n), 0);

    enable = 1'b0;
    step();
    chk(!settled && !tuning && lock_det_n, "R9", int'(settled), 0);
    saw = 0;
    for (int j = 0; j < 20; j++) begin step(); if (upd_tick) saw++; end
    chk(saw == 0, "R9", saw, 0);
    enable = 1'b1;
    step();
    chk(tuning == 1'b1, "R4", int'(tuning), 1);

    new_freq = 1'b1;
    step();
    new_freq = 1'b0;
    saw = 0;
    for (int j = 0; j < 600 && saw < 50; j++) begin step(); if (upd_tick) saw++; end
    chk(saw == 50 && !settled, "R12", saw, 50);
    for (int j = 0; j < 6; j++) step();
    new_freq = 1'b1;
    step();
    new_freq = 1'b0;
    chk(!settled && tuning && !upd_tick, "R12", int'(settled), 0);

    r_val = 13'd3;
    step();
    chk(r_error == 1'b1, "R10", int'(r_error), 1);
    r_val = 13'd7;
    for (int j = 0; j < 5; j++) step();
    chk(r_error && !tuning, "R11", int'(r_error), 1);
    enable = 1'b0;
    step();
    step();
    chk(r_error == 1'b1, "R11", int'(r_error), 1);
    enable = 1'b1;
    step();
    chk(!r_error && tuning, "R11", int'(r_error), 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule